// File: doc/BRIEF.md
# Floating-Point Exception Status Unit

This block keeps the exception state of a stack-based floating-point unit. It holds a 16-bit status word. On each request it merges newly raised exception flags into the sticky bits of that word, reads the exception masks of a 16-bit control word, and returns the set of unmasked exceptions that must trap. The condition bit C1 is rewritten according to what caused the exception. Precision traps are always deferred. An unmasked overflow or underflow is handled in one of two ways, depending on whether the destination is memory or a register.

Stack faults are presented as separate overflow and underflow requests. When the invalid-operation exception is masked, the block drives a small command interface toward the register stack: push, pop, and a write of the default NaN into a stack slot. The register file applies these commands in a fixed order: push first, then the write, then the pop. After the stack action the block raises the matching stack-fault exception. Every request completes in one clock cycle, and its effects appear on the registered outputs after the next rising edge.

Top module: `fpx_status_unit`

## Requirements
- R1: Status bits 0–6 (invalid, denormal, divide-by-zero, overflow, underflow, precision, stack fault) and bit 9 (C1) of a request are ORed into the status word. All other request bits are ignored. Bits 0–6 are never cleared except by reset, with the one exception allowed by R7.
- R2: The returned trap set (`trap_bits[5:0]`, same bit positions as the status word) is the updated status bits 0–5 ANDed with the inverse of control bits 0–5, where 1 means masked. R5, R6 and R7 then refine this set.
- R3: When the unmasked set before refinement is non-zero, status bit 7 (error summary) and bit 15 (busy) are both set. Both bits are sticky.
- R4: When a request carries stack fault (bit 6) or precision (bit 5) but not C1 (bit 9), C1 is cleared in the status word.
- R5: Precision (bit 5) never appears in the trap set.
- R6: With a register destination (`req_to_mem`=0), overflow and underflow (bits 3 and 4) are removed from the trap set.
- R7: With a memory destination and an unmasked overflow or underflow, those bits stay in the trap set and C1 is cleared. Status bit 5 is also cleared unless it was already set before the request.
- R8: A stack-overflow request with invalid masked (control bit 0 = 1) pushes, then writes the default NaN to slot 0. In all cases it raises invalid, stack fault and C1=1.
- R9: A stack-underflow request with invalid masked writes the default NaN to `unf_slot`, and pops only when `unf_pop` is 1. In all cases it raises invalid and stack fault with C1 cleared.
- R10: With invalid unmasked, stack requests issue no push, pop or write.
- R11: When several requests arrive together, stack overflow wins, then stack underflow, then a plain request. In a cycle with no request, the next cycle's trap set and stack commands are all zero.
- R12: After reset the status word, trap set and stack commands are zero.
- R13: The write data is the 80-bit default NaN: sign 1, exponent 7FFF hex, significand C000_0000_0000_0000 hex.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 16 | Control word; bits 0–5 are exception masks |
| req_valid | input | 1 | Plain exception request strobe |
| req_flags | input | 16 | Raised exception flags in status-word layout |
| req_to_mem | input | 1 | Destination of the faulting operation is memory |
| ovf_req | input | 1 | Stack-overflow response request |
| unf_req | input | 1 | Stack-underflow response request |
| unf_slot | input | SLOT_W | Stack slot addressed by an underflow |
| unf_pop | input | 1 | Underflow instruction pops the stack |
| status_word | output | 16 | Status word |
| trap_bits | output | 6 | Unmasked exceptions to trap, one-cycle result |
| stk_push | output | 1 | Push the register stack |
| stk_pop | output | 1 | Pop the register stack |
| stk_wr_en | output | 1 | Write the default NaN |
| stk_wr_slot | output | SLOT_W | Slot written, relative to the top after the push |
| stk_wr_data | output | 80 | Default NaN value |

## Verification
The bench builds the block with the default SLOT_W of 3. This makes all eight underflow slots reachable, and the bench sweeps each of them with and without a pop under both invalid-mask settings. The main sweep uses all 128 combinations of the seven exception flags against all 64 mask settings. Around that it varies C1, the destination kind, junk request bits, upper control bits, and a preceding precision exception, so every path of the C1 and memory-destination rules is taken with the prior precision bit both set and clear.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int WORD_W   = 16;
    localparam int EXC_N    = 6;
    localparam int NAN_W    = 80;

    // status / control bit positions
    localparam int B_INV    = 0;
    localparam int B_DEN    = 1;
    localparam int B_DZ     = 2;
    localparam int B_OVF    = 3;
    localparam int B_UNF    = 4;
    localparam int B_PREC   = 5;
    localparam int B_SFLT   = 6;
    localparam int B_SUM    = 7;
    localparam int B_C1     = 9;
    localparam int B_BUSY   = 15;

    // request bits that are retained in the status word
    localparam logic [WORD_W-1:0] KEEP_MASK =
        WORD_W'((1 << B_C1) | ((1 << (B_SFLT + 1)) - 1));

    localparam logic [WORD_W-1:0] OVF_FLAGS =
        WORD_W'((1 << B_INV) | (1 << B_SFLT) | (1 << B_C1));
    localparam logic [WORD_W-1:0] UNF_FLAGS =
        WORD_W'((1 << B_INV) | (1 << B_SFLT));

    localparam logic [NAN_W-1:0] DEFAULT_NAN =
        {1'b1, 15'h7FFF, 64'hC000_0000_0000_0000};

    typedef struct packed {
        logic              active;
        logic              to_mem;
        logic [WORD_W-1:0] flags;
    } exc_req_t;

endpackage

// File: rtl/fpx_fault_encoder.sv
module fpx_fault_encoder
    import fpx_pkg::*;
#(
    parameter int SLOT_W = 3
) (
    input  logic              req_valid,
    input  logic [WORD_W-1:0] req_flags,
    input  logic              req_to_mem,
    input  logic              ovf_req,
    input  logic              unf_req,
    input  logic [SLOT_W-1:0] unf_slot,
    input  logic              unf_pop,
    input  logic              inv_masked,
    output exc_req_t          sel_req,
    output logic              do_push,
    output logic              do_pop,
    output logic              do_wr,
    output logic [SLOT_W-1:0] wr_slot
);

    always_comb begin
        sel_req = '0;
        do_push = 1'b0;
        do_pop  = 1'b0;
        do_wr   = 1'b0;
        wr_slot = '0;
        if (ovf_req) begin
            sel_req.active = 1'b1;
            sel_req.flags  = OVF_FLAGS;
            if (inv_masked) begin
                do_push = 1'b1;
                do_wr   = 1'b1;
            end
        end else if (unf_req) begin
            sel_req.active = 1'b1;
            sel_req.flags  = UNF_FLAGS;
            if (inv_masked) begin
                do_wr   = 1'b1;
                wr_slot = unf_slot;
                do_pop  = unf_pop;
            end
        end else if (req_valid) begin
            sel_req.active = 1'b1;
            sel_req.flags  = req_flags;
            sel_req.to_mem = req_to_mem;
        end
    end

endmodule

// File: rtl/fpx_status_next.sv
module fpx_status_next
    import fpx_pkg::*;
(
    input  logic [WORD_W-1:0] old_status,
    input  exc_req_t          req,
    input  logic [EXC_N-1:0]  mask_bits,
    output logic [WORD_W-1:0] new_status,
    output logic [EXC_N-1:0]  trap_set
);

    logic [WORD_W-1:0] kept;
    logic [WORD_W-1:0] merged;
    logic [EXC_N-1:0]  raw_unmasked;

    assign kept   = req.flags & KEEP_MASK;
    assign merged = old_status | kept;

    for (genvar i = 0; i < EXC_N; i++) begin : g_unmask
        assign raw_unmasked[i] = merged[i] & ~mask_bits[i];
    end

    always_comb begin
        new_status = old_status;
        trap_set   = '0;
        if (req.active) begin
            new_status = merged;
            trap_set   = raw_unmasked;
            if (|raw_unmasked) begin
                new_status[B_SUM]  = 1'b1;
                new_status[B_BUSY] = 1'b1;
            end
            if ((kept[B_SFLT] | kept[B_PREC]) && !kept[B_C1]) begin
                new_status[B_C1] = 1'b0;
            end
            trap_set[B_PREC] = 1'b0;
            if (trap_set[B_OVF] | trap_set[B_UNF]) begin
                if (!req.to_mem) begin
                    trap_set[B_OVF] = 1'b0;
                    trap_set[B_UNF] = 1'b0;
                end else begin
                    new_status[B_C1] = 1'b0;
                    if (!old_status[B_PREC]) begin
                        new_status[B_PREC] = 1'b0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit
    import fpx_pkg::*;
#(
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       ctrl_word,
    input  logic              req_valid,
    input  logic [15:0]       req_flags,
    input  logic              req_to_mem,
    input  logic              ovf_req,
    input  logic              unf_req,
    input  logic [SLOT_W-1:0] unf_slot,
    input  logic              unf_pop,
    output logic [15:0]       status_word,
    output logic [5:0]        trap_bits,
    output logic              stk_push,
    output logic              stk_pop,
    output logic              stk_wr_en,
    output logic [SLOT_W-1:0] stk_wr_slot,
    output logic [79:0]       stk_wr_data
);

    typedef struct packed {
        logic [WORD_W-1:0] status;
        logic [EXC_N-1:0]  trap;
        logic              push;
        logic              pop;
        logic              wr;
        logic [SLOT_W-1:0] slot;
    } unit_state_t;

    unit_state_t st_d, st_q;

    exc_req_t          sel_req;
    logic              enc_push, enc_pop, enc_wr;
    logic [SLOT_W-1:0] enc_slot;
    logic [WORD_W-1:0] nxt_status;
    logic [EXC_N-1:0]  nxt_trap;
    logic [WORD_W-EXC_N-1:0] unused_ctrl_hi;

    assign unused_ctrl_hi = ctrl_word[WORD_W-1:EXC_N];

    fpx_fault_encoder #(.SLOT_W(SLOT_W)) enc_i (
        .req_valid  (req_valid),
        .req_flags  (req_flags),
        .req_to_mem (req_to_mem),
        .ovf_req    (ovf_req),
        .unf_req    (unf_req),
        .unf_slot   (unf_slot),
        .unf_pop    (unf_pop),
        .inv_masked (ctrl_word[B_INV]),
        .sel_req    (sel_req),
        .do_push    (enc_push),
        .do_pop     (enc_pop),
        .do_wr      (enc_wr),
        .wr_slot    (enc_slot)
    );

    fpx_status_next nxt_i (
        .old_status (st_q.status),
        .req        (sel_req),
        .mask_bits  (ctrl_word[EXC_N-1:0]),
        .new_status (nxt_status),
        .trap_set   (nxt_trap)
    );

    always_comb begin
        st_d        = st_q;
        st_d.status = nxt_status;
        st_d.trap   = nxt_trap;
        st_d.push   = enc_push;
        st_d.pop    = enc_pop;
        st_d.wr     = enc_wr;
        st_d.slot   = enc_slot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_word = st_q.status;
    assign trap_bits   = st_q.trap;
    assign stk_push    = st_q.push;
    assign stk_pop     = st_q.pop;
    assign stk_wr_en   = st_q.wr;
    assign stk_wr_slot = st_q.slot;
    assign stk_wr_data = DEFAULT_NAN;

endmodule

// File: rtl/fpx_status_unit_chk.sv
module fpx_status_unit_chk #(
    parameter int SLOT_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [5:0]        ctrl_mask,
    input logic              req_valid,
    input logic              req_to_mem,
    input logic              ovf_req,
    input logic              unf_req,
    input logic [6:0]        exc_status,
    input logic              sum_bit,
    input logic              busy_bit,
    input logic [5:0]        trap_bits,
    input logic              stk_push,
    input logic              stk_pop,
    input logic              stk_wr_en,
    input logic [SLOT_W-1:0] stk_wr_slot
);

    logic any_req;
    assign any_req = req_valid | ovf_req | unf_req;

    AST_STICKY_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(exc_status) & ~exc_status) == 7'd0)); // R1

    AST_TRAP_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |=> ((trap_bits & $past(ctrl_mask)) == 6'd0)); // R2

    AST_TRAP_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_bits != 6'd0) |-> (sum_bit && busy_bit)); // R3

    AST_NO_PREC_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |=> !trap_bits[5]); // R5

    AST_REG_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ovf_req && !unf_req && !req_to_mem) |=> (trap_bits[4:3] == 2'b00)); // R6

    AST_OVF_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_req && ctrl_mask[0]) |=> (stk_push && stk_wr_en && !stk_pop && stk_wr_slot == '0)); // R8

    AST_UNMASKED_NO_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovf_req || unf_req) && !ctrl_mask[0]) |=> !(stk_push || stk_pop || stk_wr_en)); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !any_req |=> (trap_bits == 6'd0 && !stk_push && !stk_pop && !stk_wr_en)); // R11

endmodule

bind fpx_status_unit fpx_status_unit_chk #(.SLOT_W(SLOT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_mask   (ctrl_word[5:0]),
    .req_valid   (req_valid),
    .req_to_mem  (req_to_mem),
    .ovf_req     (ovf_req),
    .unf_req     (unf_req),
    .exc_status  (status_word[6:0]),
    .sum_bit     (status_word[7]),
    .busy_bit    (status_word[15]),
    .trap_bits   (trap_bits),
    .stk_push    (stk_push),
    .stk_pop     (stk_pop),
    .stk_wr_en   (stk_wr_en),
    .stk_wr_slot (stk_wr_slot)
);

// File: tb/fpx_status_unit_tb_top.sv
module fpx_status_unit_tb_top;

    localparam int SLOT_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       ctrl_word = '0;
    logic              req_valid = 1'b0;
    logic [15:0]       req_flags = '0;
    logic              req_to_mem = 1'b0;
    logic              ovf_req = 1'b0;
    logic              unf_req = 1'b0;
    logic [SLOT_W-1:0] unf_slot = '0;
    logic              unf_pop = 1'b0;
    logic [15:0]       status_word;
    logic [5:0]        trap_bits;
    logic              stk_push, stk_pop, stk_wr_en;
    logic [SLOT_W-1:0] stk_wr_slot;
    logic [79:0]       stk_wr_data;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    fpx_status_unit #(.SLOT_W(SLOT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
        .req_valid(req_valid), .req_flags(req_flags), .req_to_mem(req_to_mem),
        .ovf_req(ovf_req), .unf_req(unf_req), .unf_slot(unf_slot), .unf_pop(unf_pop),
        .status_word(status_word), .trap_bits(trap_bits),
        .stk_push(stk_push), .stk_pop(stk_pop), .stk_wr_en(stk_wr_en),
        .stk_wr_slot(stk_wr_slot), .stk_wr_data(stk_wr_data)
    );

    // expected {trap[5:0], status[15:0]} from the requirements
    function automatic logic [21:0] ref_update(input logic [15:0] old_s,
                                               input logic [15:0] flags,
                                               input logic [15:0] ctrl,
                                               input logic mem);
        logic [15:0] s;
        logic [5:0]  um;
        s  = old_s | (flags & 16'h027F);              // R1
        um = s[5:0] & ~ctrl[5:0];                     // R2
        if (um != 6'd0) s = s | 16'h8080;             // R3
        if ((flags[6] || flags[5]) && !flags[9]) s[9] = 1'b0; // R4
        um[5] = 1'b0;                                 // R5
        if (um[4] || um[3]) begin
            if (!mem) um[4:3] = 2'b00;                // R6
            else begin                                // R7
                s[9] = 1'b0;
                if (!old_s[5]) s[5] = 1'b0;
            end
        end
        return {um, s};
    endfunction

    task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_reset();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle_inputs();
        req_valid = 1'b0; ovf_req = 1'b0; unf_req = 1'b0;
        unf_pop = 1'b0; unf_slot = '0; req_to_mem = 1'b0; req_flags = '0;
    endtask

    task automatic sweep_case(input int idx);
        logic [15:0] f, c, old_s;
        logic        m, pre;
        logic [21:0] e;
        f = 16'(idx[6:0]);
        if (idx[13]) f[9] = 1'b1;
        if (idx[0] ^ idx[8]) f = f | 16'hFD80;        // ignored bits (R1)
        c = 16'(idx[12:7]);
        if (idx[1]) c = c | 16'hFFC0;
        m   = idx[14];
        pre = ^idx[14:0];
        old_s = pre ? 16'h0020 : 16'h0000;
        pulse_reset();
        if (pre) begin
            ctrl_word = 16'h003F; req_flags = 16'h0020; req_valid = 1'b1;
            @(negedge clk);
        end
        ctrl_word = c; req_flags = f; req_to_mem = m; req_valid = 1'b1;
        @(negedge clk);
        idle_inputs();
        e = ref_update(old_s, f, c, m);
        chk("R1 R3 R4 R7 status", 80'(status_word), 80'(e[15:0]));
        chk("R2 R5 R6 R7 trap", 80'(trap_bits), 80'(e[21:16]));
        chk("R11 plain request has no stack command",
            80'({stk_push, stk_pop, stk_wr_en}), 80'(0));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fails, n_checks + 1);
        $finish;
    end

    initial begin
        logic [21:0] e;
        idle_inputs();
        repeat (2) @(negedge clk);
        chk("R12 reset status", 80'(status_word), 80'(0));
        chk("R12 reset trap", 80'(trap_bits), 80'(0));
        chk("R12 reset stack", 80'({stk_push, stk_pop, stk_wr_en, stk_wr_slot}), 80'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // near-exhaustive flag x mask x destination sweep
        for (int i = 0; i < 32768; i++) sweep_case(i);

        // stack overflow / underflow responses
        for (int im = 0; im < 2; im++) begin
            for (int sl = 0; sl < 8; sl++) begin
                for (int pp = 0; pp < 2; pp++) begin
                    pulse_reset();
                    ctrl_word = 16'h003E | 16'(im);
                    ovf_req = 1'b1; unf_slot = 3'(sl); unf_pop = pp[0];
                    @(negedge clk);
                    idle_inputs();
                    e = ref_update(16'h0, 16'h0241, 16'h003E | 16'(im), 1'b0);
                    chk("R8 overflow status C1=1", 80'(status_word), 80'(e[15:0]));
                    chk("R8 overflow trap", 80'(trap_bits), 80'(e[21:16]));
                    if (im == 1) begin
                        chk("R8 masked overflow push+write slot 0",
                            80'({stk_push, stk_pop, stk_wr_en, stk_wr_slot}), 80'({3'b101, 3'd0}));
                        chk("R13 default NaN", stk_wr_data, {1'b1, 15'h7FFF, 64'hC000_0000_0000_0000});
                    end else begin
                        chk("R10 unmasked overflow no stack command",
                            80'({stk_push, stk_pop, stk_wr_en}), 80'(0));
                    end

                    pulse_reset();
                    ctrl_word = 16'h003E | 16'(im);
                    unf_req = 1'b1; unf_slot = 3'(sl); unf_pop = pp[0];
                    @(negedge clk);
                    idle_inputs();
                    e = ref_update(16'h0, 16'h0041, 16'h003E | 16'(im), 1'b0);
                    chk("R9 underflow status C1=0", 80'(status_word), 80'(e[15:0]));
                    chk("R9 underflow trap", 80'(trap_bits), 80'(e[21:16]));
                    if (im == 1) begin
                        chk("R9 masked underflow write slot, pop on request",
                            80'({stk_push, stk_pop, stk_wr_en, stk_wr_slot}),
                            80'({1'b0, pp[0], 1'b1, 3'(sl)}));
                        chk("R13 default NaN", stk_wr_data, {1'b1, 15'h7FFF, 64'hC000_0000_0000_0000});
                    end else begin
                        chk("R10 unmasked underflow no stack command",
                            80'({stk_push, stk_pop, stk_wr_en}), 80'(0));
                    end
                    // idle cycle after the request
                    @(negedge clk);
                    chk("R11 idle cycle quiet",
                        80'({trap_bits, stk_push, stk_pop, stk_wr_en}), 80'(0));
                end
            end
        end

        // priority: overflow beats underflow beats plain request
        pulse_reset();
        ctrl_word = 16'h003F;
        ovf_req = 1'b1; unf_req = 1'b1; unf_slot = 3'd5; unf_pop = 1'b1;
        req_valid = 1'b1; req_flags = 16'h0008; req_to_mem = 1'b1;
        @(negedge clk);
        idle_inputs();
        chk("R11 overflow wins status", 80'(status_word), 80'(16'h0241));
        chk("R11 overflow wins stack",
            80'({stk_push, stk_pop, stk_wr_en, stk_wr_slot}), 80'({3'b101, 3'd0}));

        pulse_reset();
        ctrl_word = 16'h003F;
        unf_req = 1'b1; unf_slot = 3'd6; unf_pop = 1'b0;
        req_valid = 1'b1; req_flags = 16'h0204;
        @(negedge clk);
        idle_inputs();
        chk("R11 underflow beats plain status", 80'(status_word), 80'(16'h0041));
        chk("R11 underflow beats plain stack",
            80'({stk_push, stk_pop, stk_wr_en, stk_wr_slot}), 80'({3'b001, 3'd6}));

        // sticky accumulation across requests with C1 rewrite
        pulse_reset();
        ctrl_word = 16'h0037;                          // overflow unmasked
        req_valid = 1'b1; req_flags = 16'h0208; req_to_mem = 1'b0;
        @(negedge clk);
        req_flags = 16'h0004;
        @(negedge clk);
        idle_inputs();
        chk("R1 R3 sticky accumulate status", 80'(status_word), 80'(16'h828C));
        chk("R6 register dest drops overflow trap", 80'(trap_bits), 80'(0));

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule